// File: doc/BRIEF.md
# Hardware Cursor Overlay Engine

This block draws a 32x32 pointer over a pixel stream on its way to the display. Each clock it receives a raster coordinate, the RGB555 pixel already chosen for that coordinate, and the sync and display-enable flags. Two cycles later it sends out the same flags and either the original pixel or a pixel changed by the cursor. The cursor image is held in local flip-flop storage as 1024 sixteen-bit entries. Each entry is one of three things: an opaque RGB555 colour, a transparent hole, or a pattern that is XORed onto the underlying pixel. XOR with all ones inverts the pixel.

Software sets the enable, the position and the aligned base address through a small register port. The image can be loaded in two ways. The first writes one 16-bit entry at a byte address. The second turns a pair of monochrome AND/XOR mask bytes into eight entries in one cycle. Position updates are applied at once, with no double buffering. Software therefore picks a moment when the raster is away from the cursor rows.

Top module: `cursor_overlay`

## Requirements
- R1: `pix_o`, `hsync_o`, `vsync_o` and `de_o` reflect the inputs presented exactly two clock cycles earlier, with a fixed latency of 2.
- R2: With the cursor enabled, the raster point (x, y) is covered when 0 <= x-PX < 32 and 0 <= y-PY < 32, where PX and PY are the cursor position. A covered point uses cursor entry (y-PY)*32 + (x-PX). Any other point passes `pix_i` through unchanged.
- R3: A covered point whose cursor entry has bit 15 set outputs the entry's bits 14:0. Entry 0xFFFF gives white (0x7FFF) and entry 0x8000 gives black (0x0000).
- R4: A covered point whose cursor entry has bit 15 clear outputs `pix_i` XOR the entry's bits 14:0. Entry 0x0000 leaves the pixel unchanged, and entry 0x7FFF inverts it.
- R5: A register write with `reg_sel_i`=0 loads the enable from `reg_wdata_i` bit 0. While the enable is 0, every pixel passes through unchanged.
- R6: A register write with `reg_sel_i`=1 loads X from `reg_wdata_i[11:0]` and Y from `reg_wdata_i[27:16]`. The new position applies to the raster input presented in the cycle after the write cycle.
- R7: A register write with `reg_sel_i`=2 loads the base address. Bits 10:0 of that write are ignored.
  - A direct write stores `bm_data_i` in entry `bm_addr_i[10:1]` only when `bm_addr_i[31:11]` equals the stored base bits 31:11.
  - Any other direct write leaves the image unchanged.
- R8: A monochrome write to byte index `mono_idx_i` sets the eight entries that start at entry `mono_idx_i`*8, that is, row idx[6:2] and column idx[1:0]*8.
  - Mask bit 7 maps to the first entry of the group.
  - The AND/XOR bit pairs map as follows: 0/0 gives 0xFFFF, 0/1 gives 0x8000, 1/1 gives 0x7FFF, and 1/0 gives 0x0000.
- R9: When `mono_we_i` and `bm_we_i` are asserted in the same cycle, the monochrome write is performed and the direct write is dropped.
- R10: After reset, all outputs are 0, the cursor is disabled, the position and base are 0, and every image entry is 0x0000 (transparent).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raster_x_i | input | 12 | Current raster column |
| raster_y_i | input | 12 | Current raster line |
| pix_i | input | 15 | Underlying RGB555 pixel |
| hsync_i | input | 1 | Horizontal sync, delayed through the block |
| vsync_i | input | 1 | Vertical sync, delayed through the block |
| de_i | input | 1 | Display enable, delayed through the block |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 enable, 1 position, 2 base |
| reg_wdata_i | input | 32 | Register write data |
| bm_we_i | input | 1 | Direct image write strobe |
| bm_addr_i | input | 32 | Byte address of the direct write |
| bm_data_i | input | 16 | Cursor entry to store |
| mono_we_i | input | 1 | Monochrome mask write strobe |
| mono_idx_i | input | 7 | Mask byte index: row in 6:2, column group in 1:0 |
| mono_and_i | input | 8 | AND mask byte |
| mono_xor_i | input | 8 | XOR mask byte |
| pix_o | output | 15 | Pixel with the cursor applied |
| hsync_o | output | 1 | Delayed horizontal sync |
| vsync_o | output | 1 | Delayed vertical sync |
| de_o | output | 1 | Delayed display enable |

## Verification
The bench uses the default parameters: 12-bit coordinates, a 32-entry cursor edge, 16-bit entries, 8 entries per storage word and 32-bit addresses.

The image is first filled through direct writes, and some writes are aimed at a wrong 2 KB page. The bench then moves a cursor across raster scans that cover every entry kind, the window edges on all four sides, and a window pushed against the top of the coordinate range, where the x+31 bound would not fit in 12 bits. Mid-scan position writes test the one-cycle take-up. Monochrome writes that collide with direct writes in the same cycle test the write priority.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_POS  = 2'd1,
    SEL_BASE = 2'd2
  } reg_sel_e;

  // AND/XOR mask pair to 16-bit cursor entry
  function automatic logic [15:0] mono_to_entry(input logic and_b, input logic xor_b);
    case ({and_b, xor_b})
      2'b00:   return 16'hFFFF;
      2'b01:   return 16'h8000;
      2'b11:   return 16'h7FFF;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/cursor_mono_conv.sv
module cursor_mono_conv #(
  parameter int LANES = 8,
  parameter int PIX_W = 16
) (
  input  logic [LANES-1:0]       and_i,
  input  logic [LANES-1:0]       xor_i,
  output logic [LANES*PIX_W-1:0] entries_o
);
  import cursor_pkg::*;

  // lane 0 takes the mask MSB (leftmost pixel)
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign entries_o[l*PIX_W +: PIX_W] =
      PIX_W'(mono_to_entry(and_i[LANES-1-l], xor_i[LANES-1-l]));
  end

endmodule

// File: rtl/cursor_bitmap_ram.sv
module cursor_bitmap_ram #(
  parameter int WORDS = 128,
  parameter int LANES = 8,
  parameter int PIX_W = 16,
  localparam int AW   = $clog2(WORDS),
  localparam int DW   = LANES * PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LANES-1:0] lane_en_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
    end else if (we_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_en_i[l]) mem_q[waddr_i][l*PIX_W +: PIX_W] <= wdata_i[l*PIX_W +: PIX_W];
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/cursor_window.sv
module cursor_window #(
  parameter int COORD_W = 12,
  parameter int CUR_DIM = 32,
  localparam int DIM_W  = $clog2(CUR_DIM)
) (
  input  logic [COORD_W-1:0] raster_x_i,
  input  logic [COORD_W-1:0] raster_y_i,
  input  logic [COORD_W-1:0] pos_x_i,
  input  logic [COORD_W-1:0] pos_y_i,
  output logic               hit_o,
  output logic [DIM_W-1:0]   dx_o,
  output logic [DIM_W-1:0]   dy_o
);

  // one extra bit keeps the borrow, so no x+DIM overflow at the coordinate top
  logic [COORD_W:0] dx, dy;
  logic hit_x, hit_y;

  assign dx    = {1'b0, raster_x_i} - {1'b0, pos_x_i};
  assign dy    = {1'b0, raster_y_i} - {1'b0, pos_y_i};
  assign hit_x = !dx[COORD_W] && (dx[COORD_W-1:0] < COORD_W'(CUR_DIM));
  assign hit_y = !dy[COORD_W] && (dy[COORD_W-1:0] < COORD_W'(CUR_DIM));
  assign hit_o = hit_x && hit_y;
  assign dx_o  = dx[DIM_W-1:0];
  assign dy_o  = dy[DIM_W-1:0];

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int COORD_W = 12,
  parameter int CUR_DIM = 32,
  parameter int PIX_W   = 16,
  parameter int ADDR_W  = 32,
  parameter int LANES   = 8,
  localparam int RGB_W    = PIX_W - 1,
  localparam int DIM_W    = $clog2(CUR_DIM),
  localparam int NPIX     = CUR_DIM * CUR_DIM,
  localparam int WORDS    = NPIX / LANES,
  localparam int WORD_W   = $clog2(WORDS),
  localparam int LANE_W   = $clog2(LANES),
  localparam int PIDX_W   = $clog2(NPIX),
  localparam int BYTE_OFF = $clog2(NPIX * PIX_W / 8),
  localparam int POS_Y_LSB = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [COORD_W-1:0] raster_x_i,
  input  logic [COORD_W-1:0] raster_y_i,
  input  logic [RGB_W-1:0]   pix_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               de_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_sel_i,
  input  logic [ADDR_W-1:0]  reg_wdata_i,
  input  logic               bm_we_i,
  input  logic [ADDR_W-1:0]  bm_addr_i,
  input  logic [PIX_W-1:0]   bm_data_i,
  input  logic               mono_we_i,
  input  logic [WORD_W-1:0]  mono_idx_i,
  input  logic [LANES-1:0]   mono_and_i,
  input  logic [LANES-1:0]   mono_xor_i,
  output logic [RGB_W-1:0]   pix_o,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o
);
  import cursor_pkg::*;

  // ---------------- register port ----------------
  logic                       ctrl_en_q;
  logic [COORD_W-1:0]         pos_x_q, pos_y_q;
  logic [ADDR_W-1:BYTE_OFF]   base_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q <= 1'b0;
      pos_x_q   <= '0;
      pos_y_q   <= '0;
      base_hi_q <= '0;
    end else if (reg_we_i) begin
      case (reg_sel_e'(reg_sel_i))
        SEL_CTRL: ctrl_en_q <= reg_wdata_i[0];
        SEL_POS: begin
          pos_x_q <= reg_wdata_i[COORD_W-1:0];
          pos_y_q <= reg_wdata_i[POS_Y_LSB +: COORD_W];
        end
        SEL_BASE: base_hi_q <= reg_wdata_i[ADDR_W-1:BYTE_OFF];
        default: ;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{reg_wdata_i, bm_addr_i[0]};

  // ---------------- image write path ----------------
  logic [LANES*PIX_W-1:0] mono_entries;
  logic [PIDX_W-1:0]      direct_pidx;
  logic                   direct_hit;
  logic                   ram_we;
  logic [LANES-1:0]       ram_lane_en;
  logic [WORD_W-1:0]      ram_waddr;
  logic [LANES*PIX_W-1:0] ram_wdata;

  cursor_mono_conv #(.LANES(LANES), .PIX_W(PIX_W)) u_mono_conv (
    .and_i     (mono_and_i),
    .xor_i     (mono_xor_i),
    .entries_o (mono_entries)
  );

  assign direct_pidx = bm_addr_i[BYTE_OFF-1:1];
  assign direct_hit  = bm_we_i && (bm_addr_i[ADDR_W-1:BYTE_OFF] == base_hi_q);

  // mono path has priority; a colliding direct write is dropped
  always_comb begin
    ram_we      = 1'b0;
    ram_lane_en = '0;
    ram_waddr   = '0;
    ram_wdata   = '0;
    if (mono_we_i) begin
      ram_we      = 1'b1;
      ram_lane_en = '1;
      ram_waddr   = mono_idx_i;
      ram_wdata   = mono_entries;
    end else if (direct_hit) begin
      ram_we      = 1'b1;
      ram_lane_en = LANES'(1) << direct_pidx[LANE_W-1:0];
      ram_waddr   = direct_pidx[PIDX_W-1:LANE_W];
      ram_wdata   = {LANES{bm_data_i}};
    end
  end

  // ---------------- stage 1: window compare ----------------
  logic               win_hit;
  logic [DIM_W-1:0]   win_dx, win_dy;

  cursor_window #(.COORD_W(COORD_W), .CUR_DIM(CUR_DIM)) u_window (
    .raster_x_i (raster_x_i),
    .raster_y_i (raster_y_i),
    .pos_x_i    (pos_x_q),
    .pos_y_i    (pos_y_q),
    .hit_o      (win_hit),
    .dx_o       (win_dx),
    .dy_o       (win_dy)
  );

  logic               s1_hit;
  logic [PIDX_W-1:0]  s1_pidx;
  logic [RGB_W-1:0]   s1_pix;
  logic               s1_hs, s1_vs, s1_de;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_hit  <= 1'b0;
      s1_pidx <= '0;
      s1_pix  <= '0;
      s1_hs   <= 1'b0;
      s1_vs   <= 1'b0;
      s1_de   <= 1'b0;
    end else begin
      s1_hit  <= win_hit && ctrl_en_q;
      s1_pidx <= {win_dy, win_dx};
      s1_pix  <= pix_i;
      s1_hs   <= hsync_i;
      s1_vs   <= vsync_i;
      s1_de   <= de_i;
    end
  end

  // ---------------- stage 2: fetch and blend ----------------
  logic [LANES*PIX_W-1:0] ram_rdata;
  logic [PIX_W-1:0]       cur_entry;
  logic [RGB_W-1:0]       blended;

  cursor_bitmap_ram #(.WORDS(WORDS), .LANES(LANES), .PIX_W(PIX_W)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ram_we),
    .lane_en_i (ram_lane_en),
    .waddr_i   (ram_waddr),
    .wdata_i   (ram_wdata),
    .raddr_i   (s1_pidx[PIDX_W-1:LANE_W]),
    .rdata_o   (ram_rdata)
  );

  assign cur_entry = ram_rdata[s1_pidx[LANE_W-1:0]*PIX_W +: PIX_W];

  always_comb begin
    if (!s1_hit)              blended = s1_pix;
    else if (cur_entry[RGB_W]) blended = cur_entry[RGB_W-1:0];
    else                       blended = s1_pix ^ cur_entry[RGB_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o   <= '0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
    end else begin
      pix_o   <= blended;
      hsync_o <= s1_hs;
      vsync_o <= s1_vs;
      de_o    <= s1_de;
    end
  end

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int COORD_W = 12,
  parameter int CUR_DIM = 32,
  parameter int RGB_W   = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [COORD_W-1:0] raster_x_i,
  input logic [COORD_W-1:0] raster_y_i,
  input logic [RGB_W-1:0]   pix_i,
  input logic               hsync_i,
  input logic               vsync_i,
  input logic               de_i,
  input logic [RGB_W-1:0]   pix_o,
  input logic               hsync_o,
  input logic               vsync_o,
  input logic               de_o,
  input logic               ctrl_en_i,
  input logic [COORD_W-1:0] pos_x_i,
  input logic [COORD_W-1:0] pos_y_i
);

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  logic outside;
  always_comb begin
    outside = (raster_x_i < pos_x_i) || (raster_y_i < pos_y_i) ||
              ({1'b0, raster_x_i} >= {1'b0, pos_x_i} + (COORD_W+1)'(CUR_DIM)) ||
              ({1'b0, raster_y_i} >= {1'b0, pos_y_i} + (COORD_W+1)'(CUR_DIM));
  end

  // R1
  hsync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (hsync_o == $past(hsync_i, 2)));
  // R1
  vsync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (vsync_o == $past(vsync_i, 2)));
  // R1
  de_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (de_o == $past(de_i, 2)));
  // R5
  disabled_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && !$past(ctrl_en_i, 2)) |-> (pix_o == $past(pix_i, 2)));
  // R2
  outside_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && $past(outside, 2)) |-> (pix_o == $past(pix_i, 2)));

endmodule

bind cursor_overlay cursor_overlay_chk #(
  .COORD_W (COORD_W),
  .CUR_DIM (CUR_DIM),
  .RGB_W   (RGB_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .raster_x_i (raster_x_i),
  .raster_y_i (raster_y_i),
  .pix_i      (pix_i),
  .hsync_i    (hsync_i),
  .vsync_i    (vsync_i),
  .de_i       (de_i),
  .pix_o      (pix_o),
  .hsync_o    (hsync_o),
  .vsync_o    (vsync_o),
  .de_o       (de_o),
  .ctrl_en_i  (ctrl_en_q),
  .pos_x_i    (pos_x_q),
  .pos_y_i    (pos_y_q)
);

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] raster_x_i = '0, raster_y_i = '0;
  logic [14:0] pix_i = '0;
  logic        hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        bm_we_i = 1'b0;
  logic [31:0] bm_addr_i = '0;
  logic [15:0] bm_data_i = '0;
  logic        mono_we_i = 1'b0;
  logic [6:0]  mono_idx_i = '0;
  logic [7:0]  mono_and_i = '0, mono_xor_i = '0;
  logic [14:0] pix_o;
  logic        hsync_o, vsync_o, de_o;

  always #5 clk_i = ~clk_i;

  cursor_overlay u_cursor_overlay (.*);

  int checks = 0;
  int errors = 0;
  bit chk_on = 0;
  bit done = 0;
  string phase = "R10";

  // ---------------- reference model ----------------
  logic [15:0] mem_m [1024];
  bit          en_m;
  int          px_m, py_m;
  logic [31:0] base_m;
  bit          s1_hit_m, s1_en_m;
  int          s1_idx_m;
  logic [14:0] s1_pix_m;
  bit          s1_hs_m, s1_vs_m, s1_de_m;
  logic [14:0] exp_pix;
  bit          exp_hs, exp_vs, exp_de;
  string       exp_tag;

  function automatic logic [15:0] mono_entry(bit a, bit x);
    if (!a && !x) return 16'hFFFF;
    if (!a &&  x) return 16'h8000;
    if ( a &&  x) return 16'h7FFF;
    return 16'h0000;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (mem_m[i]) mem_m[i] = 16'h0000;
      en_m = 0; px_m = 0; py_m = 0; base_m = '0;
      s1_hit_m = 0; s1_en_m = 0; s1_idx_m = 0; s1_pix_m = '0;
      s1_hs_m = 0; s1_vs_m = 0; s1_de_m = 0;
      exp_pix = '0; exp_hs = 0; exp_vs = 0; exp_de = 0; exp_tag = "R10";
    end else begin
      // output stage
      exp_hs = s1_hs_m; exp_vs = s1_vs_m; exp_de = s1_de_m;
      if (!s1_hit_m) begin
        exp_pix = s1_pix_m;
        exp_tag = s1_en_m ? "R2" : "R5";
      end else if (mem_m[s1_idx_m][15]) begin
        exp_pix = mem_m[s1_idx_m][14:0];
        exp_tag = "R3";
      end else begin
        exp_pix = s1_pix_m ^ mem_m[s1_idx_m][14:0];
        exp_tag = "R4";
      end
      // compare stage
      begin
        int rx, ry;
        rx = int'(raster_x_i); ry = int'(raster_y_i);
        s1_en_m  = en_m;
        s1_hit_m = en_m && rx >= px_m && rx - px_m < 32 && ry >= py_m && ry - py_m < 32;
        s1_idx_m = s1_hit_m ? (ry - py_m) * 32 + (rx - px_m) : 0;
        s1_pix_m = pix_i;
        s1_hs_m = hsync_i; s1_vs_m = vsync_i; s1_de_m = de_i;
      end
      // writes
      if (mono_we_i) begin
        for (int l = 0; l < 8; l++)
          mem_m[int'(mono_idx_i) * 8 + l] = mono_entry(mono_and_i[7-l], mono_xor_i[7-l]);
      end else if (bm_we_i && bm_addr_i[31:11] == base_m[31:11]) begin
        mem_m[int'(bm_addr_i[10:1])] = bm_data_i;
      end
      if (reg_we_i) begin
        case (reg_sel_i)
          2'd0: en_m = reg_wdata_i[0];
          2'd1: begin px_m = int'(reg_wdata_i[11:0]); py_m = int'(reg_wdata_i[27:16]); end
          2'd2: base_m = reg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk_i) begin
    if (chk_on && rst_ni && !done) begin
      checks++;
      if (pix_o !== exp_pix) begin
        errors++;
        $display("FAIL %s (phase %s) pix_o actual %h expected %h", exp_tag, phase, pix_o, exp_pix);
      end
      checks++;
      if ({hsync_o, vsync_o, de_o} !== {exp_hs, exp_vs, exp_de}) begin
        errors++;
        $display("FAIL R1 (phase %s) syncs actual %b expected %b", phase,
                 {hsync_o, vsync_o, de_o}, {exp_hs, exp_vs, exp_de});
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    reg_we_i = 0; bm_we_i = 0; mono_we_i = 0;
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] data);
    reg_we_i = 1; reg_sel_i = sel; reg_wdata_i = data;
    step();
  endtask

  function automatic logic [31:0] pos_word(int x, int y);
    return {4'h0, 12'(y), 4'h0, 12'(x)};
  endfunction

  task automatic scan(int x0, int nx, int y0, int ny, int move_every, int mx, int my);
    for (int y = y0; y < y0 + ny; y++) begin
      for (int x = x0; x < x0 + nx; x++) begin
        raster_x_i = 12'(x); raster_y_i = 12'(y);
        pix_i   = 15'((x * 37 + y * 101 + 5) & 16'h7FFF);
        hsync_i = (x % 7) == 0; vsync_i = (y % 4) >= 2; de_i = ((x ^ y) & 1) != 0;
        if (move_every > 0 && (x % move_every) == 0) begin
          reg_we_i = 1; reg_sel_i = 2'd1;
          reg_wdata_i = pos_word(mx + (x / move_every) % 5, my + (x / move_every) % 3);
        end
        step();
      end
    end
  endtask

  function automatic logic [15:0] pattern(int p);
    case (p % 6)
      0: return 16'hFFFF;
      1: return 16'h8000;
      2: return 16'h0000;
      3: return 16'h7FFF;
      4: return 16'h8000 | 16'((p * 131) & 16'h7FFF);
      default: return 16'((p * 197) & 16'h7FFF);
    endcase
  endfunction

  task automatic report();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // watchdog
  int cycles = 0;
  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog expired actual %0d cycles expected < 150000", cycles);
      report();
    end
  end

  initial begin
    // R10: reset state at the ports
    repeat (3) @(negedge clk_i);
    checks++;
    if ({pix_o, hsync_o, vsync_o, de_o} !== '0) begin
      errors++;
      $display("FAIL R10 outputs in reset actual %h expected 0", {pix_o, hsync_o, vsync_o, de_o});
    end
    rst_ni = 1;
    @(negedge clk_i);
    chk_on = 1;

    // R10: disabled, then enabled over a transparent image
    phase = "R10";
    scan(0, 40, 0, 2, 0, 0, 0);
    reg_wr(2'd0, 32'h1);
    scan(0, 40, 0, 34, 0, 0, 0);

    // R7: fill through direct writes, base with dirty low bits
    phase = "R7";
    reg_wr(2'd2, 32'h0001_27FF);
    for (int p = 0; p < 1024; p++) begin
      bm_we_i = 1; bm_addr_i = 32'h0001_2000 + 32'(p * 2); bm_data_i = pattern(p);
      step();
    end
    for (int p = 0; p < 64; p += 3) begin
      bm_we_i = 1; bm_addr_i = 32'h0001_2800 + 32'(p * 2); bm_data_i = 16'h8123;
      step();
      bm_we_i = 1; bm_addr_i = 32'h0000_2000 + 32'(p * 2); bm_data_i = 16'h8456;
      step();
    end

    // R2, R3, R4: window with all entry kinds and all four edges
    phase = "R2";
    reg_wr(2'd1, pos_word(100, 50));
    scan(95, 42, 47, 38, 0, 0, 0);
    // window at top of coordinate range
    reg_wr(2'd1, pos_word(4080, 4070));
    scan(4070, 26, 4060, 36, 0, 0, 0);

    // R6: position moves mid-scan, applied on the next pixel
    phase = "R6";
    reg_wr(2'd1, pos_word(20, 10));
    scan(10, 60, 8, 40, 9, 18, 9);

    // R5: disabled passes through
    phase = "R5";
    reg_wr(2'd1, pos_word(0, 0));
    reg_wr(2'd0, 32'hFFFF_FFFE);
    scan(0, 36, 0, 33, 0, 0, 0);
    reg_wr(2'd0, 32'h1);

    // R8: monochrome loading
    phase = "R8";
    for (int i = 0; i < 128; i++) begin
      mono_we_i = 1; mono_idx_i = 7'(i);
      mono_and_i = 8'((i * 29 + 3) & 8'hFF);
      mono_xor_i = 8'((i * 53 + 7) & 8'hFF);
      if (i == 0) begin mono_and_i = 8'b0011_0011; mono_xor_i = 8'b0101_0101; end
      step();
    end
    scan(0, 33, 0, 33, 0, 0, 0);

    // R9: colliding writes, mono wins
    phase = "R9";
    mono_we_i = 1; mono_idx_i = 7'd5; mono_and_i = 8'h0F; mono_xor_i = 8'h33;
    bm_we_i = 1; bm_addr_i = 32'h0001_2000 + 32'(41 * 2); bm_data_i = 16'h8123;
    step();
    mono_we_i = 1; mono_idx_i = 7'd9; mono_and_i = 8'hF0; mono_xor_i = 8'hCC;
    bm_we_i = 1; bm_addr_i = 32'h0001_2000 + 32'(500 * 2); bm_data_i = 16'h8456;
    step();
    scan(0, 32, 1, 2, 0, 0, 0);
    scan(0, 32, 15, 1, 0, 0, 0);

    // R7: base moved, old page ignored, new page accepted
    phase = "R7";
    reg_wr(2'd2, 32'h0004_0000);
    for (int p = 0; p < 32; p++) begin
      bm_we_i = 1; bm_addr_i = 32'h0001_2000 + 32'(p * 2); bm_data_i = 16'h8777;
      step();
      bm_we_i = 1; bm_addr_i = 32'h0004_0000 + 32'((p + 32) * 2); bm_data_i = 16'h8000 | 16'(p);
      step();
    end
    scan(0, 32, 0, 3, 0, 0, 0);

    repeat (3) step();
    report();
  end

endmodule